// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Format Rescaling

This block multiplies two signed two's-complement operands, each given in a fixed-point format with a caller-chosen number of fractional bits. It forms the exact double-width product and then narrows it back to a single operand-sized word in a requested output format. The product keeps as many fractional bits as the two operands have together. Narrowing drops the excess low fractional bits by arithmetic right shift, which truncates toward minus infinity, and keeps the word above them. An overflow flag is raised when the kept word cannot hold the shifted product.

Two operand widths are supported: a narrow mode that uses the low half of each operand port and a wide mode that uses the full port. The full product is twice the operand width. The unit is fully pipelined. A start strobe captures operands and format fields, and the result appears two clocks later together with a one-cycle valid strobe. New operations may be started on every cycle.

Top module: `qmul_top`

## Requirements
- R1: The result is the signed product a*b shifted arithmetically right by (a_frac + b_frac - out_frac) bits. Its low W bits (W = 8 when wide_i=0, 16 when wide_i=1) are sign-extended to 16 bits. A zero operand gives result 0 with no overflow.
- R2: In narrow mode with 7 fractional bits on both operands and on the output, 0x20 (0.25) times 0x60 (0.75) gives 0x0018 (0.1875). In wide mode with 15 fractional bits everywhere, 0x2000 times 0x6000 gives 0x1800.
- R3: ovf_o is 1 exactly when the shifted product lies outside the signed W-bit range. result_o then holds the wrapped low W bits, sign-extended.
- R4: When both operands and the output are pure fractions (W-1 fractional bits), ovf_o is 0 for every operand pair except most-negative times most-negative, which sets ovf_o.
- R5: In narrow mode, bits 15:8 of a_i and b_i have no effect, and result_o bits 15:7 are all equal.
- R6: An operand fractional-width field above W-1 is treated as W-1.
- R7: An out_frac_i above a_frac + b_frac is treated as a_frac + b_frac, so no left shift occurs.
- R8: valid_o is 1 in the second cycle after a cycle with start_i=1, and only then. Starts on consecutive cycles each produce their own result in order.
- R9: While valid_o is 0, result_o and ovf_o keep their last values.
- R10: After reset, valid_o, ovf_o and result_o are 0.
- R11: Dropped fractional bits are truncated toward minus infinity. For example, in narrow mode Q0.7, 0xFF times 0x40 gives 0xFFFF, and 0x01 times 0x40 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture operands and formats this cycle |
| wide_i | input | 1 | 1: 16-bit operands, 0: 8-bit operands in the low byte |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_frac_i | input | 4 | Fractional bit count of a_i |
| b_frac_i | input | 4 | Fractional bit count of b_i |
| out_frac_i | input | 5 | Fractional bit count of the result |
| valid_o | output | 1 | Result strobe, two cycles after start_i |
| result_o | output | 16 | Rescaled product, sign-extended from W bits |
| ovf_o | output | 1 | Rescaled product did not fit in W bits |

## Verification
There are two faults an internal error would most likely cause at the ports. A wrong shift amount or a wrong format clamp gives a result off by a power of two. A bad sign extension of an operand gives a result with the wrong sign. Either one shows on result_o in the same valid cycle as the faulty operation, two clocks after its start. A faulty fit check shows on ovf_o in that same cycle, so the pure-fraction extremes and the integer-range boundaries are run in both modes. A pipeline register that loads or holds at the wrong time shows as a missing or extra valid pulse, or as results out of order in a back-to-back run.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } qmul_mode_e;
endpackage

// File: rtl/qmul_prep.sv
module qmul_prep
  import qmul_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int HALF_W = MAX_W / 2,
  localparam int FW = $clog2(MAX_W)
) (
  input  qmul_mode_e               mode_i,
  input  logic [MAX_W-1:0]         op_i,
  input  logic [FW-1:0]            frac_i,
  output logic signed [MAX_W-1:0]  op_o,
  output logic [FW-1:0]            frac_o
);
  localparam logic [FW-1:0] LIM_WIDE   = FW'(MAX_W - 1);
  localparam logic [FW-1:0] LIM_NARROW = FW'(HALF_W - 1);

  logic [FW-1:0] lim;

  always_comb begin
    if (mode_i == MODE_WIDE) begin
      op_o = op_i;
      lim  = LIM_WIDE;
    end else begin
      op_o = {{HALF_W{op_i[HALF_W-1]}}, op_i[HALF_W-1:0]};
      lim  = LIM_NARROW;
    end
    frac_o = (frac_i > lim) ? lim : frac_i;
  end
endmodule

// File: rtl/qmul_prod.sv
module qmul_prod
  import qmul_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int PW = 2 * MAX_W,
  localparam int FW = $clog2(MAX_W),
  localparam int SW = FW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  qmul_mode_e              mode_i,
  input  logic signed [MAX_W-1:0] a_i,
  input  logic signed [MAX_W-1:0] b_i,
  input  logic [FW-1:0]           a_frac_i,
  input  logic [FW-1:0]           b_frac_i,
  input  logic [SW-1:0]           out_frac_i,
  output logic                    vld_o,
  output qmul_mode_e              mode_o,
  output logic signed [PW-1:0]    prod_o,
  output logic [SW-1:0]           shift_o
);
  logic signed [PW-1:0] a_ext, b_ext, prod_d;
  logic [SW-1:0] tot, keep, shift_d;

  assign a_ext  = {{MAX_W{a_i[MAX_W-1]}}, a_i};
  assign b_ext  = {{MAX_W{b_i[MAX_W-1]}}, b_i};
  assign prod_d = a_ext * b_ext;

  // product fraction = sum of operand fractions; never shift left
  assign tot     = SW'(a_frac_i) + SW'(b_frac_i);
  assign keep    = (out_frac_i > tot) ? tot : out_frac_i;
  assign shift_d = tot - keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      mode_o  <= MODE_NARROW;
      prod_o  <= '0;
      shift_o <= '0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        mode_o  <= mode_i;
        prod_o  <= prod_d;
        shift_o <= shift_d;
      end
    end
  end
endmodule

// File: rtl/qmul_narrow.sv
module qmul_narrow
  import qmul_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int HALF_W = MAX_W / 2,
  localparam int PW = 2 * MAX_W,
  localparam int FW = $clog2(MAX_W),
  localparam int SW = FW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  qmul_mode_e           mode_i,
  input  logic signed [PW-1:0] prod_i,
  input  logic [SW-1:0]        shift_i,
  output logic                 vld_o,
  output logic [MAX_W-1:0]     result_o,
  output logic                 ovf_o
);
  logic signed [PW-1:0] shifted, fit_narrow, fit_wide, fitted;
  logic ovf_d;

  assign shifted    = prod_i >>> shift_i;
  assign fit_narrow = {{(PW-HALF_W){shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
  assign fit_wide   = {{(PW-MAX_W){shifted[MAX_W-1]}}, shifted[MAX_W-1:0]};
  assign fitted     = (mode_i == MODE_WIDE) ? fit_wide : fit_narrow;
  // dropped upper bits must all be copies of the kept sign bit
  assign ovf_d      = (fitted != shifted);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        result_o <= fitted[MAX_W-1:0];
        ovf_o    <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/qmul_top.sv
module qmul_top
  import qmul_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int PW = 2 * MAX_W,
  localparam int FW = $clog2(MAX_W),
  localparam int SW = FW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [MAX_W-1:0] a_i,
  input  logic [MAX_W-1:0] b_i,
  input  logic [FW-1:0]    a_frac_i,
  input  logic [FW-1:0]    b_frac_i,
  input  logic [SW-1:0]    out_frac_i,
  output logic             valid_o,
  output logic [MAX_W-1:0] result_o,
  output logic             ovf_o
);
  qmul_mode_e mode;
  logic signed [MAX_W-1:0] a_op, b_op;
  logic [FW-1:0] a_frac, b_frac;
  logic s1_vld;
  qmul_mode_e s1_mode;
  logic signed [PW-1:0] s1_prod;
  logic [SW-1:0] s1_shift;

  assign mode = wide_i ? MODE_WIDE : MODE_NARROW;

  qmul_prep #(.MAX_W(MAX_W)) prep_a_i (
    .mode_i(mode), .op_i(a_i), .frac_i(a_frac_i), .op_o(a_op), .frac_o(a_frac)
  );

  qmul_prep #(.MAX_W(MAX_W)) prep_b_i (
    .mode_i(mode), .op_i(b_i), .frac_i(b_frac_i), .op_o(b_op), .frac_o(b_frac)
  );

  qmul_prod #(.MAX_W(MAX_W)) prod_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode),
    .a_i(a_op), .b_i(b_op), .a_frac_i(a_frac), .b_frac_i(b_frac),
    .out_frac_i(out_frac_i), .vld_o(s1_vld), .mode_o(s1_mode),
    .prod_o(s1_prod), .shift_o(s1_shift)
  );

  qmul_narrow #(.MAX_W(MAX_W)) narrow_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s1_vld), .mode_i(s1_mode),
    .prod_i(s1_prod), .shift_i(s1_shift), .vld_o(valid_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/qmul_chk.sv
module qmul_chk #(
  parameter int MAX_W = 16,
  localparam int HALF_W = MAX_W / 2,
  localparam int FW = $clog2(MAX_W),
  localparam int SW = FW + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             wide_i,
  input logic [MAX_W-1:0] a_i,
  input logic [MAX_W-1:0] b_i,
  input logic [FW-1:0]    a_frac_i,
  input logic [FW-1:0]    b_frac_i,
  input logic [SW-1:0]    out_frac_i,
  input logic             valid_o,
  input logic [MAX_W-1:0] result_o,
  input logic             ovf_o
);
  logic pf_now, mm_now, zero_now;

  always_comb begin
    if (wide_i) begin
      pf_now   = (a_frac_i == FW'(MAX_W-1)) && (b_frac_i == FW'(MAX_W-1)) &&
                 (out_frac_i == SW'(MAX_W-1));
      mm_now   = (a_i == {1'b1, {(MAX_W-1){1'b0}}}) && (b_i == {1'b1, {(MAX_W-1){1'b0}}});
      zero_now = (a_i == '0) || (b_i == '0);
    end else begin
      pf_now   = (a_frac_i == FW'(HALF_W-1)) && (b_frac_i == FW'(HALF_W-1)) &&
                 (out_frac_i == SW'(HALF_W-1));
      mm_now   = (a_i[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}}) &&
                 (b_i[HALF_W-1:0] == {1'b1, {(HALF_W-1){1'b0}}});
      zero_now = (a_i[HALF_W-1:0] == '0) || (b_i[HALF_W-1:0] == '0);
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 valid_o); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i, 2)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(pf_now && !mm_now, 2)) |-> !ovf_o); // R4
  AST_MINMIN_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(pf_now && mm_now, 2)) |-> ovf_o); // R4
  AST_ZERO_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(zero_now, 2)) |-> (result_o == '0 && !ovf_o)); // R1
  AST_NARROW_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(wide_i, 2)) |->
      (result_o[MAX_W-1:HALF_W-1] == '0 || result_o[MAX_W-1:HALF_W-1] == '1)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(ovf_o))); // R9
endmodule

bind qmul_top qmul_chk #(.MAX_W(MAX_W)) chk_i (.*);

// File: tb/qmul_top_tb_top.sv
`timescale 1ns/1ps
module qmul_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [3:0]  a_frac_i = '0, b_frac_i = '0;
  logic [4:0]  out_frac_i = '0;
  logic        valid_o;
  logic [15:0] result_o;
  logic        ovf_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  qmul_top dut_i (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected value from the requirements alone
  task automatic model(input bit wide, input logic [15:0] a, input logic [15:0] b,
                       input int fa_in, input int fb_in, input int fo_in,
                       output logic [15:0] r, output bit ov);
    int w, fa, fb, fo, tot;
    longint sa, sb, p, s, hi;
    w  = wide ? 16 : 8;
    fa = (fa_in > w - 1) ? w - 1 : fa_in;
    fb = (fb_in > w - 1) ? w - 1 : fb_in;
    tot = fa + fb;
    fo = (fo_in > tot) ? tot : fo_in;
    sa = wide ? longint'($signed(a)) : longint'($signed(a[7:0]));
    sb = wide ? longint'($signed(b)) : longint'($signed(b[7:0]));
    p  = sa * sb;
    s  = p >>> (tot - fo);
    hi = (longint'(1) << (w - 1)) - 1;
    ov = (s > hi) || (s < -hi - 1);
    r  = wide ? s[15:0] : {{8{s[7]}}, s[7:0]};
  endtask

  task automatic drive(input bit st, input bit wide, input logic [15:0] a,
                       input logic [15:0] b, input int fa, input int fb, input int fo);
    start_i = st; wide_i = wide; a_i = a; b_i = b;
    a_frac_i = fa[3:0]; b_frac_i = fb[3:0]; out_frac_i = fo[4:0];
  endtask

  task automatic run_op(input string req, input bit wide, input logic [15:0] a,
                        input logic [15:0] b, input int fa, input int fb, input int fo,
                        output logic [15:0] got);
    logic [15:0] er;
    bit eo;
    model(wide, a, b, fa, fb, fo, er, eo);
    @(negedge clk_i);
    drive(1'b1, wide, a, b, fa, fb, fo);
    @(negedge clk_i);
    start_i = 1'b0;
    check("R8", "valid one cycle after start", 32'(valid_o), 32'd0);
    @(negedge clk_i);
    check("R8", "valid two cycles after start", 32'(valid_o), 32'd1);
    check(req, "result", 32'(result_o), 32'(er));
    check(req, "overflow", 32'(ovf_o), 32'(eo));
    got = result_o;
    @(negedge clk_i);
    check("R8", "single valid pulse", 32'(valid_o), 32'd0);
  endtask

  task automatic t_reset;
    check("R10", "valid in reset", 32'(valid_o), 32'd0);
    check("R10", "result in reset", 32'(result_o), 32'd0);
    check("R10", "ovf in reset", 32'(ovf_o), 32'd0);
  endtask

  task automatic t_frac_example;
    logic [15:0] g;
    run_op("R2", 1'b0, 16'h0020, 16'h0060, 7, 7, 7, g);
    check("R2", "narrow 0.25*0.75", 32'(g), 32'h0018);
    run_op("R2", 1'b1, 16'h2000, 16'h6000, 15, 15, 15, g);
    check("R2", "wide 0.25*0.75", 32'(g), 32'h1800);
  endtask

  task automatic t_mixed_formats;
    logic [15:0] g;
    run_op("R1", 1'b0, 16'h0028, 16'h0018, 4, 4, 4, g);
    run_op("R1", 1'b1, 16'h0030, 16'h0050, 3, 5, 6, g);
    run_op("R1", 1'b1, 16'hFFD0, 16'h0050, 3, 5, 6, g);
    check("R1", "negative mixed", 32'(g), 32'h0000FC40);
    run_op("R1", 1'b1, 16'h0000, 16'h7FFF, 15, 15, 15, g);
  endtask

  task automatic t_floor;
    logic [15:0] g;
    run_op("R11", 1'b0, 16'h00FF, 16'h0040, 7, 7, 7, g);
    check("R11", "negative floors down", 32'(g), 32'h0000FFFF);
    run_op("R11", 1'b0, 16'h0001, 16'h0040, 7, 7, 7, g);
    check("R11", "positive floors to zero", 32'(g), 32'h0);
  endtask

  task automatic t_overflow;
    logic [15:0] g;
    run_op("R3", 1'b0, 16'h0014, 16'h000A, 0, 0, 0, g);
    run_op("R3", 1'b1, 16'd300, 16'd300, 0, 0, 0, g);
    run_op("R3", 1'b0, 16'h0080, 16'h0001, 0, 0, 0, g);
    run_op("R3", 1'b0, 16'h007F, 16'h0001, 0, 0, 0, g);
  endtask

  task automatic t_pure_frac;
    logic [15:0] g;
    run_op("R4", 1'b0, 16'h0080, 16'h0080, 7, 7, 7, g);
    check("R4", "narrow min*min wraps", 32'(g), 32'h0000FF80);
    run_op("R4", 1'b1, 16'h8000, 16'h8000, 15, 15, 15, g);
    run_op("R4", 1'b0, 16'h0081, 16'h0080, 7, 7, 7, g);
    run_op("R4", 1'b1, 16'h7FFF, 16'h8000, 15, 15, 15, g);
  endtask

  task automatic t_mode_ignore;
    logic [15:0] g;
    run_op("R5", 1'b0, 16'hAB20, 16'h5560, 7, 7, 7, g);
    check("R5", "upper operand bits ignored", 32'(g), 32'h0018);
  endtask

  task automatic t_clamp;
    logic [15:0] g;
    run_op("R6", 1'b0, 16'h0020, 16'h0060, 15, 15, 7, g);
    check("R6", "fraction width clamped", 32'(g), 32'h0018);
    run_op("R7", 1'b0, 16'h0006, 16'h000A, 2, 2, 31, g);
    check("R7", "no left shift", 32'(g), 32'h003C);
  endtask

  task automatic t_pipeline;
    logic [15:0] e0, e1, e2;
    bit o0, o1, o2;
    model(1'b0, 16'h0020, 16'h0060, 7, 7, 7, e0, o0);
    model(1'b1, 16'hFFD0, 16'h0050, 3, 5, 6, e1, o1);
    model(1'b0, 16'h0014, 16'h000A, 0, 0, 0, e2, o2);
    @(negedge clk_i);
    drive(1'b1, 1'b0, 16'h0020, 16'h0060, 7, 7, 7);
    @(negedge clk_i);
    drive(1'b1, 1'b1, 16'hFFD0, 16'h0050, 3, 5, 6);
    @(negedge clk_i);
    drive(1'b1, 1'b0, 16'h0014, 16'h000A, 0, 0, 0);
    check("R8", "b2b valid 0", 32'(valid_o), 32'd1);
    check("R8", "b2b result 0", 32'(result_o), 32'(e0));
    @(negedge clk_i);
    drive(1'b0, 1'b1, 16'h1234, 16'h4321, 0, 0, 0);
    check("R8", "b2b valid 1", 32'(valid_o), 32'd1);
    check("R8", "b2b result 1", 32'(result_o), 32'(e1));
    @(negedge clk_i);
    check("R8", "b2b valid 2", 32'(valid_o), 32'd1);
    check("R8", "b2b result 2", 32'(result_o), 32'(e2));
    check("R8", "b2b ovf 2", 32'(ovf_o), 32'(o2));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      a_i = a_i + 16'h0101;
      check("R9", "idle valid low", 32'(valid_o), 32'd0);
      check("R9", "idle result held", 32'(result_o), 32'(e2));
      check("R9", "idle ovf held", 32'(ovf_o), 32'(o2));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_frac_example();
    t_mixed_formats();
    t_floor();
    t_overflow();
    t_pure_frac();
    t_mode_ignore();
    t_clamp();
    t_pipeline();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule